// File: doc/BRIEF.md
# Open-Drain Two-Pin Pad Control Register

This block is a single 32-bit control register that lets software toggle two open-drain pads, a clock line and a data line, to produce a two-wire serial bus by hand. Each pin has a direction field and an output level field. Each field has its own write-enable bit that travels in the same write word. A write therefore changes only the fields it asks to change and leaves every other field as it was. The register does not generate pulses and does not follow any protocol timing; software supplies the sequence.

The pads are never driven high. A pin is pulled low only while its direction is output and its stored level is zero. In every other case the pad is released and an external pull-up takes the line high. The current level of each pad passes through a two-stage synchroniser and software reads it back from the register. To sample a line that another device may be holding low, software first writes the pin back to input. Two pull-up disable bits are plain read/write storage, and they drive the pads' pull-up controls.

Top module: `gpio_pad_reg`

## Requirements
- R1: Each pin's direction bit (1 = output) loads from the write word only when that pin's direction write-enable is set in the same write. Otherwise it keeps its value. For pin k, the write-enable is at bit 8k and the direction at bit 8k+1.
- R2: Each pin's level bit loads from the write word only when that pin's level write-enable is set in the same write. Otherwise it keeps its value. For pin k, the write-enable is at bit 8k+2 and the level at bit 8k+3.
- R3: pad_oe[k] is high exactly when pin k's direction is output and its stored level is 0. pad_out is always 0.
- R4: Bit 8k+4 of rdata shows pad_in[k] after a two-flop synchroniser. A change on a pad becomes visible after the second rising clock edge that follows it. Write data in this bit position is ignored.
- R5: The pull-up disable bits (bit 16 for the clock pin, bit 17 for the data pin) load on every write, read back at the same positions, and drive pad_pu_dis.
- R6: The write-enable bits (8k and 8k+2) and all unused bits read as 0. Direction reads at 8k+1 and level at 8k+3.
- R7: After reset, both pins are inputs, both levels are 0, both pull-up disable bits are 0 and no pad is pulled low.
- R8: When wr_en is low, no stored field changes, whatever wdata holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write word |
| rdata | output | 32 | Register readback |
| pad_in | input | 2 | Pad levels, bit 0 clock pin, bit 1 data pin |
| pad_oe | output | 2 | Open-drain pull-down enables |
| pad_out | output | 2 | Pad output data, held at 0 |
| pad_pu_dis | output | 2 | Pull-up disable controls |

## Verification
The hardest case to reach is a write that carries new direction and level values while their write-enables are clear. Such a write still updates the pull-up bits, so it must leave the pin fields unchanged. The stimulus table first puts both pins into different non-reset states, then sends writes with the enables withheld for one field at a time, and reads back both the register and the pad enables. The synchroniser delay is checked by changing a pad and sampling rdata after one edge and again after two.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int REG_W   = 32;
    localparam int SLOT_W  = 8;
    localparam int OFF_DM  = 0;
    localparam int OFF_DIR = 1;
    localparam int OFF_VM  = 2;
    localparam int OFF_VAL = 3;
    localparam int OFF_IN  = 4;
    localparam int PU_BASE = 16;

    typedef struct packed {
        logic dir_we;
        logic dir;
        logic val_we;
        logic val;
    } pin_wr_t;

    typedef struct packed {
        logic dir;
        logic val;
        logic lvl;
    } pin_rd_t;

    function automatic pin_wr_t decode_pin(input logic [REG_W-1:0] w, input int k);
        pin_wr_t r;
        r.dir_we = w[k*SLOT_W + OFF_DM];
        r.dir    = w[k*SLOT_W + OFF_DIR];
        r.val_we = w[k*SLOT_W + OFF_VM];
        r.val    = w[k*SLOT_W + OFF_VAL];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] place_pin(input pin_rd_t p, input int k);
        logic [REG_W-1:0] r;
        r = '0;
        r[k*SLOT_W + OFF_DIR] = p.dir;
        r[k*SLOT_W + OFF_VAL] = p.val;
        r[k*SLOT_W + OFF_IN]  = p.lvl;
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pad_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  pin_wr_t wr,
    output logic    dir_q,
    output logic    val_q,
    output logic    pull_low
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= 1'b0;
            val_q <= 1'b0;
        end else if (wr_en) begin
            if (wr.dir_we) dir_q <= wr.dir;
            if (wr.val_we) val_q <= wr.val;
        end
    end

    // open drain: only an output holding zero pulls the line down
    assign pull_low = dir_q & ~val_q;
endmodule

// File: rtl/gpio_pad_reg.sv
module gpio_pad_reg
    import gpio_pad_pkg::*;
#(
    parameter int NPIN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_oe,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_pu_dis
);
    logic [NPIN-1:0] lvl_sync;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] val_q;
    logic [NPIN-1:0] pu_q;
    logic            unused_wbits;

    assign unused_wbits = ^wdata;

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl_sync)
    );

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        gpio_pin_ctl u_pin (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en),
            .wr       (decode_pin(wdata, k)),
            .dir_q    (dir_q[k]),
            .val_q    (val_q[k]),
            .pull_low (pad_oe[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        pu_q <= '0;
        else if (wr_en) pu_q <= wdata[PU_BASE +: NPIN];
    end

    always_comb begin
        pin_rd_t p;
        rdata = '0;
        for (int k = 0; k < NPIN; k++) begin
            p.dir = dir_q[k];
            p.val = val_q[k];
            p.lvl = lvl_sync[k];
            rdata = rdata | place_pin(p, k);
        end
        rdata[PU_BASE +: NPIN] = pu_q;
    end

    assign pad_out    = '0;
    assign pad_pu_dis = pu_q;
endmodule

// File: rtl/gpio_pad_reg_chk.sv
module gpio_pad_reg_chk
    import gpio_pad_pkg::*;
#(
    parameter int NPIN = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] rdata,
    input logic [NPIN-1:0]  pad_in,
    input logic [NPIN-1:0]  pad_oe,
    input logic [NPIN-1:0]  pad_pu_dis
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    for (genvar k = 0; k < NPIN; k++) begin : g_chk
        localparam int B = k*SLOT_W;

        assert_dir_load_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wdata[B+OFF_DM]) |=> rdata[B+OFF_DIR] == $past(wdata[B+OFF_DIR]));
        assert_dir_hold_R1: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wdata[B+OFF_DM]) |=> $stable(rdata[B+OFF_DIR]));
        assert_val_load_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wdata[B+OFF_VM]) |=> rdata[B+OFF_VAL] == $past(wdata[B+OFF_VAL]));
        assert_val_hold_R2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !wdata[B+OFF_VM]) |=> $stable(rdata[B+OFF_VAL]));
        assert_pull_low_R3: assert property (@(posedge clk) disable iff (rst)
            pad_oe[k] == (rdata[B+OFF_DIR] && !rdata[B+OFF_VAL]));
        assert_sync_lat_R4: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2) |-> rdata[B+OFF_IN] == $past(pad_in[k], 2));
        assert_we_zero_R6: assert property (@(posedge clk) disable iff (rst)
            !rdata[B+OFF_DM] && !rdata[B+OFF_VM]);
        assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> ($stable(rdata[B+OFF_DIR]) && $stable(rdata[B+OFF_VAL])));
    end

    assert_pu_load_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pad_pu_dis == $past(wdata[PU_BASE +: NPIN]));
    assert_pu_read_R5: assert property (@(posedge clk) disable iff (rst)
        rdata[PU_BASE +: NPIN] == pad_pu_dis);
    assert_reset_R7: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && pad_pu_dis == '0));
endmodule

bind gpio_pad_reg gpio_pad_reg_chk #(.NPIN(NPIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .pad_in     (pad_in),
    .pad_oe     (pad_oe),
    .pad_pu_dis (pad_pu_dis)
);

// File: tb/tb_gpio_pad_reg.sv
`timescale 1ns/1ps
module tb_gpio_pad_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [1:0]  pad_in;
    logic [1:0]  pad_oe;
    logic [1:0]  pad_out;
    logic [1:0]  pad_pu_dis;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    gpio_pad_reg dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu_dis (pad_pu_dis)
    );

    typedef struct packed {
        logic [31:0] wr;
        logic [1:0]  pads;
        logic [31:0] exp_rd;
        logic [1:0]  exp_oe;
        logic [1:0]  exp_pu;
    } vec_t;

    // state carries from row to row
    localparam vec_t VECS [9] = '{
        '{32'h0000_0007, 2'b10, 32'h0000_1002, 2'b01, 2'b00}, // R1 R2 clk low
        '{32'h0000_0700, 2'b00, 32'h0000_0202, 2'b11, 2'b00}, // R3 data low
        '{32'h0000_0001, 2'b01, 32'h0000_0210, 2'b10, 2'b00}, // R1 release clk
        '{32'h0000_0A0A, 2'b01, 32'h0000_0210, 2'b10, 2'b00}, // R1 R2 no enables
        '{32'h0000_0C00, 2'b11, 32'h0000_1A10, 2'b00, 2'b00}, // R2 level only
        '{32'h0003_0000, 2'b11, 32'h0003_1A10, 2'b00, 2'b11}, // R5 both pu
        '{32'h0001_0000, 2'b11, 32'h0001_1A10, 2'b00, 2'b01}, // R5 clk pu
        '{32'h0000_000F, 2'b11, 32'h0000_1A1A, 2'b00, 2'b00}, // R3 out high level
        '{32'h0000_0014, 2'b10, 32'h0000_1A02, 2'b01, 2'b00}  // R4 R2 in bit ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = 32'hDEAD_BEEF;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wdata = '0; pad_in = 2'b11;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state (synchroniser has not yet caught up: levels 0)
        chk("R7 rdata", rdata & 32'hFFFF_FFEF & 32'hFFFF_EFFF, 32'h0);
        chk("R7 oe", {30'd0, pad_oe}, 32'd0);
        chk("R7 pu", {30'd0, pad_pu_dis}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R4 initial levels", rdata, 32'h0000_1010);

        foreach (VECS[i]) begin
            do_write(VECS[i].wr);
            pad_in = VECS[i].pads;
            repeat (3) @(negedge clk);
            chk($sformatf("R6 vec%0d rdata", i), rdata, VECS[i].exp_rd);
            chk($sformatf("R3 vec%0d oe", i), {30'd0, pad_oe}, {30'd0, VECS[i].exp_oe});
            chk($sformatf("R5 vec%0d pu", i), {30'd0, pad_pu_dis}, {30'd0, VECS[i].exp_pu});
            chk($sformatf("R3 vec%0d pad_out", i), {30'd0, pad_out}, 32'd0);
        end

        // R8: garbage on wdata with wr_en low changes nothing
        @(negedge clk);
        wdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        chk("R8 rdata", rdata, 32'h0000_1A02);
        chk("R8 oe", {30'd0, pad_oe}, 32'd1);

        // R4: latency of two edges
        pad_in = 2'b01;
        @(negedge clk);
        chk("R4 one edge", rdata, 32'h0000_1A02);
        @(negedge clk);
        chk("R4 two edges", rdata, 32'h0000_0A12);

        // R7: reset from a busy state
        do_write(32'h0003_0707);
        chk("R7 pre oe", {30'd0, pad_oe}, 32'd3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R7 post rdata", rdata & 32'hFFFF_EFEF, 32'h0);
        chk("R7 post oe", {30'd0, pad_oe}, 32'd0);
        chk("R7 post pu", {30'd0, pad_pu_dis}, 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule